// File: doc/BRIEF.md
# Remote Keypad Scanner with Multi-Key Lockout

This block sits in front of an infrared frame transmitter and turns a key matrix into 8-bit command codes. It drives the eight drive lines of the matrix high one at a time and samples the sense lines, which are pulled down outside the block. A key counts as present only after two consecutive full scans have both seen it. The controller then applies the timing rules of a handheld remote. These rules cover a simultaneity window in which multi-key presses cancel the command, priority for the first key, a held indication, an optional continuous-repeat mode, a minimum press-to-press spacing, and one two-key combination that sets its own code bit.

Time is measured on a one-pulse-per-millisecond tick supplied from outside. A transmission request is a one-cycle `tx_start` pulse, with the 8-bit code on `tx_data`. Bit n of `tx_data` is data bit dn, and the frame transmitter sends d0 first. Key numbering: the key on drive line `d` (0..7) and sense line `s` (0..7) has group position `p = 4*d + (s mod 4)`. Sense lines 0..3 form the first group (keys 1..32, key number `p+1`). Sense lines 4..7 form the second group (keys 33..64). With four sense lines only the first group exists.

Top module: `kp_remote_scan`

## Requirements
- R1: Exactly one drive line is high in every cycle after reset, and the lines rotate in order. A key that is not seen on two consecutive full scans never produces a transmission.
- R2: A single-key code carries the group position p in d4..d0, d5 = 0, and d6 = 1 for sense lines 0..3 or d6 = 0 for sense lines 4..7.
- R3: If a second key becomes present while the 36 ms window of the first press is still open, including shortly before it closes, no code is sent and key_held stays low until all keys are released.
- R4: The first accepted press opens a 36 ms window. `tx_start` pulses for one cycle between 36 and 39 ms after the press, even if the key was released inside the window.
- R5: A second, unrelated key that arrives after the window has closed is ignored. The first key's code is the only code sent.
- R6: d7 of every transmitted code is 0 when sel_level is 1, and 1 when sel_level is 0.
- R7: key_held rises between 108 and 112 ms after the press of a key that is still held, and falls within 5 ms of release.
- R8: With repeat_mode = 1 the same code is sent again every 108 ms while the key is held. With repeat_mode = 0 it is sent once.
- R9: A new press is accepted no sooner than 126 ms after the previous accepted press. An earlier press that is still held is deferred to that point, and its code follows 36 ms later.
- R10: Key 21 (drive 5, sense 0) held, followed at least 126 ms later by key 22, 23 or 24 (drive 5, sense 1..3), with repeat_mode = 0, sends a second code. That code has d4..d0 equal to the second key's position, d5 = 1 and d6 = 0.
- R11: If the second key of that pair arrives between 36 and 126 ms after key 21, no pair code is sent and key_held stays low until release.
- R12: With repeat_mode = 1 the pair combination is ignored, and only key 21's own code repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| sense | input | N_SENSE | Matrix sense lines, externally pulled low |
| sel_level | input | 1 | Level that selects code bit d7 |
| repeat_mode | input | 1 | 1 = resend the code every 108 ms while held |
| drive | output | N_DRIVE | One-hot matrix drive lines |
| tx_start | output | 1 | One-cycle request to send a frame |
| tx_data | output | 8 | Code for the frame, bit n = dn |
| key_held | output | 1 | Key held for at least 108 ms |

## Verification
Two functions can act in the same cycle: the close of the 36 ms window, which triggers a transmission, and a scan result that shows a second key, which triggers lockout. The design gives lockout precedence. The bench provokes this by pressing a second key 34 ms after the first, so that its second confirming scan lands just before or at the window edge. It then requires that no code appears and that no request pulse occurs at any cycle of the run. Two further cases are judged the same way from the recorded request times. In the repeat test, a repeat falls close to a scan boundary. In the pair tests, the arrival time of the second key separates the pair code from the stop case.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef logic [5:0] key_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATHER,
        ST_ACTIVE,
        ST_LOCK
    } kp_state_e;

    localparam key_idx_t PAIR_LEAD = 6'd20;
    localparam int       PAIR_LO   = 21;
    localparam int       PAIR_HI   = 23;

    function automatic logic [7:0] single_code(key_idx_t idx, logic sel);
        return {~sel, ~idx[5], 1'b0, idx[4:0]};
    endfunction

    function automatic logic [7:0] pair_code(logic [4:0] pos, logic sel);
        return {~sel, 1'b0, 1'b1, pos};
    endfunction

endpackage

// File: rtl/kp_scan.sv
module kp_scan #(
    parameter int N_DRIVE = 8,
    parameter int N_SENSE = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_SENSE-1:0]           sense,
    output logic [N_DRIVE-1:0]           drive,
    output logic [N_DRIVE*N_SENSE-1:0]   stable,
    output logic                         scan_valid
);
    localparam int NKEY = N_DRIVE * N_SENSE;
    localparam int DW   = $clog2(N_DRIVE);
    localparam int IW   = $clog2(NKEY);

    logic [DW-1:0]   row;
    logic [NKEY-1:0] acc, next_acc, prev;

    assign drive = {{(N_DRIVE-1){1'b0}}, 1'b1} << row;

    always_comb begin
        next_acc = acc;
        for (int s = 0; s < N_SENSE; s++) begin
            next_acc[IW'((s / 4) * (N_DRIVE * 4) + int'(row) * 4 + (s % 4))] = sense[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row        <= '0;
            acc        <= '0;
            prev       <= '0;
            stable     <= '0;
            scan_valid <= 1'b0;
        end else begin
            acc        <= next_acc;
            scan_valid <= 1'b0;
            if (row == DW'(N_DRIVE - 1)) begin
                row        <= '0;
                prev       <= next_acc;
                stable     <= next_acc & prev;
                scan_valid <= 1'b1;
            end else begin
                row <= row + 1'b1;
            end
        end
    end

    assert_drive_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(drive) == 1);

endmodule

// File: rtl/kp_classify.sv
module kp_classify
    import kp_pkg::*;
#(
    parameter int NKEY = 64
) (
    input  logic [NKEY-1:0] stable,
    output logic            any_key,
    output logic            multi_key,
    output key_idx_t        low_idx
);
    always_comb begin
        low_idx = '0;
        for (int i = NKEY - 1; i >= 0; i--) begin
            if (stable[i]) low_idx = key_idx_t'(i);
        end
    end

    assign any_key   = |stable;
    assign multi_key = $countones(stable) > 1;

endmodule

// File: rtl/kp_ctrl.sv
module kp_ctrl
    import kp_pkg::*;
#(
    parameter int NKEY    = 64,
    parameter int WIN_MS  = 36,
    parameter int HOLD_MS = 108,
    parameter int GAP_MS  = 126
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            scan_valid,
    input  logic [NKEY-1:0] stable,
    input  logic            any_key,
    input  logic            multi_key,
    input  key_idx_t        low_idx,
    input  logic            sel_level,
    input  logic            repeat_mode,
    output logic            tx_start,
    output logic [7:0]      tx_data,
    output logic            key_held
);
    localparam int CW = $clog2(WIN_MS + HOLD_MS + GAP_MS + 2);
    localparam logic [NKEY-1:0] ONE = {{(NKEY-1){1'b0}}, 1'b1};

    kp_state_e       st;
    key_idx_t        first;
    logic [CW-1:0]   elapsed, since_press, rpt;
    logic            pair_done;
    logic [NKEY-1:0] first_mask, other_mask;
    logic            first_present, others, pair_ok, pair_cond;
    logic [4:0]      pair_pos;

    assign first_mask    = ONE << first;
    assign other_mask    = stable & ~first_mask;
    assign first_present = |(stable & first_mask);
    assign others        = |other_mask;

    always_comb begin
        pair_ok  = 1'b0;
        pair_pos = '0;
        for (int j = PAIR_LO; j <= PAIR_HI; j++) begin
            if (j < NKEY && other_mask == (ONE << j)) begin
                pair_ok  = 1'b1;
                pair_pos = 5'(j);
            end
        end
    end

    assign pair_cond = scan_valid && pair_ok && !pair_done && !repeat_mode
                       && (first == PAIR_LEAD);
    assign key_held  = (st == ST_ACTIVE) && (elapsed >= CW'(HOLD_MS));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            first       <= '0;
            elapsed     <= '0;
            since_press <= '1;
            rpt         <= '0;
            pair_done   <= 1'b0;
            tx_start    <= 1'b0;
            tx_data     <= '0;
        end else begin
            tx_start <= 1'b0;
            if (ms_tick) begin
                if (elapsed != '1)     elapsed     <= elapsed + 1'b1;
                if (since_press != '1) since_press <= since_press + 1'b1;
                if (rpt != '1)         rpt         <= rpt + 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (scan_valid && any_key && since_press >= CW'(GAP_MS)) begin
                        if (multi_key) begin
                            st <= ST_LOCK;
                        end else begin
                            first       <= low_idx;
                            elapsed     <= '0;
                            since_press <= '0;
                            pair_done   <= 1'b0;
                            st          <= ST_GATHER;
                        end
                    end
                end
                ST_GATHER: begin
                    if (scan_valid && others) begin
                        st <= ST_LOCK;
                    end else if (elapsed >= CW'(WIN_MS)) begin
                        tx_start <= 1'b1;
                        tx_data  <= single_code(first, sel_level);
                        rpt      <= '0;
                        st       <= ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (scan_valid && !first_present) begin
                        st <= any_key ? ST_LOCK : ST_IDLE;
                    end else if (pair_cond) begin
                        pair_done <= 1'b1;
                        if (elapsed >= CW'(GAP_MS)) begin
                            tx_start <= 1'b1;
                            tx_data  <= pair_code(pair_pos, sel_level);
                        end else begin
                            st <= ST_LOCK;
                        end
                    end else if (repeat_mode && rpt >= CW'(HOLD_MS)) begin
                        tx_start <= 1'b1;
                        tx_data  <= single_code(first, sel_level);
                        rpt      <= '0;
                    end
                end
                default: begin
                    if (scan_valid && !any_key) st <= ST_IDLE;
                end
            endcase
        end
    end

    assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    assert_sel_bit_R6: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (tx_data[7] == !$past(sel_level)));

    assert_lock_no_tx_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_LOCK && st == ST_LOCK) |-> !tx_start);

    assert_pair_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_start && tx_data[5]) |-> (elapsed >= CW'(GAP_MS)));

endmodule

// File: rtl/kp_remote_scan.sv
module kp_remote_scan
    import kp_pkg::*;
#(
    parameter int N_DRIVE = 8,
    parameter int N_SENSE = 8,
    parameter int WIN_MS  = 36,
    parameter int HOLD_MS = 108,
    parameter int GAP_MS  = 126
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ms_tick,
    input  logic [N_SENSE-1:0] sense,
    input  logic               sel_level,
    input  logic               repeat_mode,
    output logic [N_DRIVE-1:0] drive,
    output logic               tx_start,
    output logic [7:0]         tx_data,
    output logic               key_held
);
    localparam int NKEY = N_DRIVE * N_SENSE;

    logic [NKEY-1:0] stable;
    logic            scan_valid, any_key, multi_key;
    key_idx_t        low_idx;

    kp_scan #(.N_DRIVE(N_DRIVE), .N_SENSE(N_SENSE)) u_scan (
        .clk(clk), .rst(rst), .sense(sense), .drive(drive),
        .stable(stable), .scan_valid(scan_valid)
    );

    kp_classify #(.NKEY(NKEY)) u_classify (
        .stable(stable), .any_key(any_key), .multi_key(multi_key), .low_idx(low_idx)
    );

    kp_ctrl #(.NKEY(NKEY), .WIN_MS(WIN_MS), .HOLD_MS(HOLD_MS), .GAP_MS(GAP_MS)) u_ctrl (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .scan_valid(scan_valid),
        .stable(stable), .any_key(any_key), .multi_key(multi_key), .low_idx(low_idx),
        .sel_level(sel_level), .repeat_mode(repeat_mode),
        .tx_start(tx_start), .tx_data(tx_data), .key_held(key_held)
    );

endmodule

// File: tb/kp_remote_scan_bench.sv
module kp_remote_scan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MS_CYC     = 16;
    localparam int ND = 8;
    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic sel_level = 1'b1;
    logic repeat_mode = 1'b0;
    logic [NS-1:0] sense;
    logic [ND-1:0] drive;
    logic tx_start, key_held;
    logic [7:0] tx_data;

    logic pressed [64];
    int   ms_now = 0;
    int   div = 0;
    int   checks = 0;
    int   fails = 0;
    bit   quiet = 1'b0;
    bit   done = 1'b0;
    int   tx_ms[$];
    int   tx_code[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kp_remote_scan u_kp_remote_scan (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .sense(sense),
        .sel_level(sel_level), .repeat_mode(repeat_mode), .drive(drive),
        .tx_start(tx_start), .tx_data(tx_data), .key_held(key_held)
    );

    function automatic int kidx(int d, int s);
        return (s / 4) * 32 + d * 4 + (s % 4);
    endfunction

    function automatic int exp_code(int idx, logic sel);
        return ((sel ? 0 : 1) << 7) | ((idx >= 32 ? 0 : 1) << 6) | (idx % 32);
    endfunction

    always_comb begin
        sense = '0;
        for (int d = 0; d < ND; d++)
            for (int s = 0; s < NS; s++)
                if (drive[d] && pressed[kidx(d, s)]) sense[s] = 1'b1;
    end

    // millisecond time base and per-clock monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_start) begin
                tx_ms.push_back(ms_now);
                tx_code.push_back(int'(tx_data));
                if (quiet) begin
                    checks++; fails++;
                    $display("FAIL R3: request at %0d ms during a quiet case, act=1 exp=0", ms_now);
                end
            end
            if ($countones(drive) != 1) begin
                checks++; fails++;
                $display("FAIL R1: drive=%b not one-hot, exp one bit", drive);
            end
        end
        div = (div == MS_CYC - 1) ? 0 : div + 1;
        ms_tick <= (div == 0) && !rst;
        if (div == 0 && !rst) ms_now++;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ms(int n);
        repeat (n * MS_CYC) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int k = 0; k < 64; k++) pressed[k] = 1'b0;
    endtask

    task automatic settle();
        clear_all();
        wait_ms(150);
        tx_ms.delete();
        tx_code.delete();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: act=expired exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        clear_all();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_start == 1'b0, "R4 reset tx_start", int'(tx_start), 0);
        chk(key_held == 1'b0, "R7 reset key_held", int'(key_held), 0);
        chk($countones(drive) == 1, "R1 reset drive", int'(drive), 1);
        settle();

        // R4/R2/R6: short tap of key 1 (drive 0, sense 0), sel high
        t0 = ms_now; pressed[kidx(0, 0)] = 1'b1;
        wait_ms(10); pressed[kidx(0, 0)] = 1'b0;
        wait_ms(60);
        chk(tx_ms.size() == 1, "R4 tap count", tx_ms.size(), 1);
        if (tx_ms.size() == 1) begin
            chk(tx_ms[0] - t0 >= 36 && tx_ms[0] - t0 <= 39, "R4 window", tx_ms[0] - t0, 36);
            chk(tx_code[0] == exp_code(0, 1'b1), "R2 R6 code", tx_code[0], exp_code(0, 1'b1));
        end
        chk(key_held == 1'b0, "R7 tap not held", int'(key_held), 0);
        settle();

        // R2/R6/R7: second group key (drive 3, sense 5), sel low, held
        sel_level = 1'b0;
        t0 = ms_now; pressed[kidx(3, 5)] = 1'b1;
        wait_ms(100);
        chk(key_held == 1'b0, "R7 held early", int'(key_held), 0);
        wait_ms(12);
        chk(key_held == 1'b1, "R7 held set", int'(key_held), 1);
        wait_ms(188);
        chk(tx_ms.size() == 1, "R8 single send", tx_ms.size(), 1);
        if (tx_ms.size() >= 1)
            chk(tx_code[0] == exp_code(45, 1'b0), "R2 R6 group two code", tx_code[0], exp_code(45, 1'b0));
        pressed[kidx(3, 5)] = 1'b0;
        wait_ms(5);
        chk(key_held == 1'b0, "R7 release", int'(key_held), 0);
        sel_level = 1'b1;
        settle();

        // R3: second key 10 ms later
        quiet = 1'b1;
        pressed[2] = 1'b1; wait_ms(10); pressed[7] = 1'b1;
        wait_ms(190);
        chk(tx_ms.size() == 0, "R3 lockout", tx_ms.size(), 0);
        chk(key_held == 1'b0, "R3 lockout held", int'(key_held), 0);
        settle();

        // R3: second key just before the window closes
        pressed[10] = 1'b1; wait_ms(34); pressed[11] = 1'b1;
        wait_ms(100);
        chk(tx_ms.size() == 0, "R3 window edge lockout", tx_ms.size(), 0);
        quiet = 1'b0;
        settle();

        // R5: unrelated second key after the window
        pressed[3] = 1'b1; wait_ms(60); pressed[9] = 1'b1;
        wait_ms(140);
        chk(tx_ms.size() == 1, "R5 priority count", tx_ms.size(), 1);
        if (tx_ms.size() >= 1)
            chk(tx_code[0] == exp_code(3, 1'b1), "R5 first key code", tx_code[0], exp_code(3, 1'b1));
        settle();

        // R8: continuous repeat
        repeat_mode = 1'b1;
        pressed[4] = 1'b1; wait_ms(350); pressed[4] = 1'b0;
        wait_ms(5);
        chk(tx_ms.size() == 3, "R8 repeat count", tx_ms.size(), 3);
        if (tx_ms.size() == 3) begin
            chk(tx_ms[1] - tx_ms[0] >= 107 && tx_ms[1] - tx_ms[0] <= 109, "R8 repeat period",
                tx_ms[1] - tx_ms[0], 108);
            chk(tx_code[2] == exp_code(4, 1'b1), "R8 repeat code", tx_code[2], exp_code(4, 1'b1));
        end
        repeat_mode = 1'b0;
        settle();

        // R9: second press 60 ms after the first is deferred to 126 ms
        t0 = ms_now; pressed[6] = 1'b1; wait_ms(20); pressed[6] = 1'b0;
        wait_ms(40); pressed[6] = 1'b1;
        wait_ms(140);
        chk(tx_ms.size() == 2, "R9 spacing count", tx_ms.size(), 2);
        if (tx_ms.size() == 2)
            chk(tx_ms[1] - t0 >= 162 && tx_ms[1] - t0 <= 166, "R9 deferred send", tx_ms[1] - t0, 162);
        settle();

        // R10: key 21 then key 22 after 130 ms
        pressed[kidx(5, 0)] = 1'b1; wait_ms(130); pressed[kidx(5, 1)] = 1'b1;
        wait_ms(40);
        chk(tx_ms.size() == 2, "R10 pair count", tx_ms.size(), 2);
        if (tx_ms.size() == 2) begin
            chk(tx_code[0] == exp_code(20, 1'b1), "R10 lead code", tx_code[0], exp_code(20, 1'b1));
            chk(tx_code[1] == 8'h35, "R10 pair code", tx_code[1], 8'h35);
        end
        settle();

        // R11: key 21 then key 23 after 80 ms
        pressed[kidx(5, 0)] = 1'b1; wait_ms(80); pressed[kidx(5, 2)] = 1'b1;
        wait_ms(40);
        chk(key_held == 1'b0, "R11 stopped held", int'(key_held), 0);
        wait_ms(60);
        chk(tx_ms.size() == 1, "R11 no pair code", tx_ms.size(), 1);
        settle();

        // R12: pair in repeat mode is ignored
        repeat_mode = 1'b1;
        pressed[kidx(5, 0)] = 1'b1; wait_ms(130); pressed[kidx(5, 3)] = 1'b1;
        wait_ms(70); clear_all(); wait_ms(5);
        chk(tx_ms.size() == 2, "R12 repeat pair count", tx_ms.size(), 2);
        if (tx_ms.size() == 2)
            chk(tx_code[1] == exp_code(20, 1'b1), "R12 lead code repeats", tx_code[1], exp_code(20, 1'b1));
        repeat_mode = 1'b0;
        settle();

        // R1: a press shorter than one scan is never accepted
        quiet = 1'b1;
        pressed[5] = 1'b1; repeat (3) @(negedge clk); pressed[5] = 1'b0;
        wait_ms(100);
        chk(tx_ms.size() == 0, "R1 glitch rejected", tx_ms.size(), 0);
        quiet = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule